// File: doc/BRIEF.md
# Predicated Vector Contiguous Doubleword Store Sequencer

This block takes one 32-bit store instruction word and the operands that go with it: a 64-bit base address, a 64-bit starting index, a vector value of `VLEN` bits and the matching predicate value, which has one bit per vector byte. It checks that the word belongs to the contiguous doubleword store class and that it is legal. It then walks through the vector's 64-bit elements in ascending order and issues one 64-bit memory write for every element whose predicate bit is set. Each write goes out on a valid/ready request channel.

The write address of element `e` is `base + (index + e) * 8`, computed modulo 2^64. The running index moves forward for every element, including elements that are masked off, and it is never reported back to the caller. When the base register field selects the stack pointer (field value 31), the base must be 16-byte aligned. Every accepted instruction ends with exactly one single-cycle outcome pulse: done, foreign (the word belongs to another instruction class), undefined, or misaligned.

The controller is a single state machine:
- IDLE goes to DECODE when `start_i` is seen.
- DECODE goes to FOREIGN, UNDEF, MISALIGN or SCAN, depending on the decode outcome.
- SCAN goes to WRITE when the current element is active. For an inactive element it moves to the next element and stays in SCAN, or goes to DONE if that element was the last.
- WRITE goes back to SCAN, or to DONE after the last element, once `wr_ready_i` is seen.
- DONE, FOREIGN, UNDEF and MISALIGN each last one cycle and return to IDLE.

Top module: `vstore_seq`

## Requirements
- R1: The word is foreign, and produces one `foreign_o` pulse and no writes, if any of these holds: bits 31:23 are not 111001011, bits 15:13 are not 010, or the size field in bits 22:21 is 00 or 01. This check takes priority over every other check.
- R2: A word that passes R1 and has size field 10 produces one `undef_o` pulse and no writes.
- R3: A word that passes R1 and R2 and has index register field bits 20:16 equal to 11111 produces one `undef_o` pulse and no writes.
- R4: Suppose a legal word has base register field bits 9:5 equal to 11111. If `base_i[3:0]` is nonzero, the block produces one `misalign_o` pulse and no writes. If `base_i[3:0]` is zero, the store proceeds. For any other field value, the base alignment is not checked.
- R5: The write for element `e` carries address `base_i + (index_i + e) * 8` modulo 2^64 and data `vdata_i[64e+63:64e]`. There are `VLEN/64` elements.
- R6: Element `e` is active exactly when `pred_i[8e]` is 1; the other bits of its 8-bit predicate slice are ignored. An inactive element produces no write, but the index still advances past it.
- R7: Writes are issued in ascending element order, at most one per cycle. While `wr_valid_o` is high and `wr_ready_i` is low, the valid signal, the address and the data all hold steady.
- R8: A legal store ends with a `done_o` pulse lasting exactly one cycle, including when no element is active. Each accepted instruction raises exactly one of the four outcome pulses.
- R9: `start_i` is ignored while `busy_o` is high. Such a pulse changes neither the writes nor the outcome of the instruction in progress.
- R10: After reset the block is idle: `busy_o`, `wr_valid_o` and all outcome pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch request; sampled only while idle |
| instr_i | input | 32 | Store instruction word |
| base_i | input | 64 | Base address (stack pointer value when field 9:5 is 31) |
| index_i | input | 64 | Starting element index |
| vdata_i | input | VLEN | Source vector value |
| pred_i | input | VLEN/8 | Governing predicate, one bit per vector byte |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Memory side accepts the write |
| wr_addr_o | output | 64 | Byte address of the doubleword write |
| wr_data_o | output | 64 | Doubleword write data |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Store completed pulse |
| foreign_o | output | 1 | Word is not in this instruction class |
| undef_o | output | 1 | Undefined encoding |
| misalign_o | output | 1 | Stack-pointer base alignment fault |

## Verification
The store path is exercised with several predicate patterns:
- All elements active, which checks the base address and index scaling.
- Alternating and sparse masks whose non-lowest slice bits are set, which separates a correct "skip but advance" from a design that compacts addresses or reads the wrong predicate bit.
- No element active, which checks that a done pulse still appears with no writes.

Bases and indices near 2^64 test address wrap-around. A stalling ready pattern shows that a held request stays steady and that ordering is kept. Encoding tests cover:
- Each size value and a broken fixed field, which separates the foreign outcome from the undefined one and checks their priority.
- Stack-pointer bases that are aligned and misaligned, alongside a misaligned ordinary base, which shows the alignment check is tied to field value 31 alone.

// File: rtl/vst_pkg.sv
package vst_pkg;

    localparam logic [8:0] OPC_HI  = 9'b111001011;
    localparam logic [2:0] OPC_MID = 3'b010;
    localparam logic [4:0] REG_SP  = 5'd31;
    localparam logic [4:0] REG_ZR  = 5'd31;
    localparam int         DW_BITS       = 64;
    localparam int         DW_SHIFT      = 3;
    localparam int         PRED_PER_ELEM = 8;
    localparam int         SP_ALIGN_BITS = 4;

    typedef struct packed {
        logic [8:0] hi;
        logic [1:0] size;
        logic [4:0] idx_reg;
        logic [2:0] mid;
        logic [2:0] pred_reg;
        logic [4:0] base_reg;
        logic [4:0] vec_reg;
    } word_t;

    typedef enum logic [1:0] {
        OUT_RUN,
        OUT_FOREIGN,
        OUT_UNDEF,
        OUT_MISALIGN
    } outcome_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DECODE,
        S_SCAN,
        S_WRITE,
        S_DONE,
        S_FOREIGN,
        S_UNDEF,
        S_MISALIGN
    } state_t;

endpackage

// File: rtl/vst_decode.sv
module vst_decode
    import vst_pkg::*;
(
    input  logic [31:0]              word_i,
    input  logic [SP_ALIGN_BITS-1:0] base_lo_i,
    output outcome_t                 outcome_o
);

    word_t f;
    assign f = word_t'(word_i);

    logic class_ok;
    logic size_bad;
    logic idx_bad;
    logic sp_bad;

    assign class_ok = (f.hi == OPC_HI) && (f.mid == OPC_MID) && f.size[1];
    assign size_bad = (f.size == 2'b10);
    assign idx_bad  = (f.idx_reg == REG_ZR);
    assign sp_bad   = (f.base_reg == REG_SP) && (base_lo_i != '0);

    // Priority: class membership, then size, then index register, then alignment.
    always_comb begin
        if (!class_ok) begin
            outcome_o = OUT_FOREIGN;
        end else if (size_bad) begin
            outcome_o = OUT_UNDEF;
        end else if (idx_bad) begin
            outcome_o = OUT_UNDEF;
        end else if (sp_bad) begin
            outcome_o = OUT_MISALIGN;
        end else begin
            outcome_o = OUT_RUN;
        end
    end

    // Register selectors for the vector and predicate are resolved by the caller.
    logic unused_fields;
    assign unused_fields = &{1'b0, f.pred_reg, f.vec_reg};

endmodule

// File: rtl/vst_addr_gen.sv
module vst_addr_gen
    import vst_pkg::*;
#(
    parameter  int NELEM = 4,
    localparam int EW    = (NELEM > 1) ? $clog2(NELEM) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic                     adv_i,
    input  logic [63:0]              base_i,
    input  logic [63:0]              index_i,
    output logic [SP_ALIGN_BITS-1:0] base_lo_o,
    output logic [63:0]              addr_o,
    output logic [EW-1:0]            elem_o,
    output logic                     last_o
);

    logic [63:0]   base_q;
    logic [63:0]   idx_q;
    logic [EW-1:0] elem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            idx_q  <= '0;
            elem_q <= '0;
        end else if (load_i) begin
            base_q <= base_i;
            idx_q  <= index_i;
            elem_q <= '0;
        end else if (adv_i) begin
            idx_q  <= idx_q + 64'd1;
            elem_q <= elem_q + EW'(1);
        end
    end

    assign base_lo_o = base_q[SP_ALIGN_BITS-1:0];
    assign addr_o    = base_q + {idx_q[63-DW_SHIFT:0], {DW_SHIFT{1'b0}}};
    assign elem_o    = elem_q;
    assign last_o    = (elem_q == EW'(NELEM - 1));

    logic unused_idx;
    assign unused_idx = &{1'b0, idx_q[63:64-DW_SHIFT]};

    // R6: the index advances by exactly one per element step, active or not.
    p_idx_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i) |=> (idx_q == $past(idx_q) + 64'd1));

    // R5: consecutive element steps move the address by one doubleword.
    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i) |=> (addr_o == $past(addr_o) + 64'd8));

endmodule

// File: rtl/vst_lane_sel.sv
module vst_lane_sel
    import vst_pkg::*;
#(
    parameter  int VLEN   = 256,
    localparam int NELEM  = VLEN / DW_BITS,
    localparam int PRED_W = VLEN / 8,
    localparam int EW     = (NELEM > 1) ? $clog2(NELEM) : 1
) (
    input  logic [VLEN-1:0]    vdata_i,
    input  logic [PRED_W-1:0]  pred_i,
    input  logic [EW-1:0]      elem_i,
    output logic [DW_BITS-1:0] data_o,
    output logic               active_o
);

    logic [DW_BITS-1:0] lane_data [NELEM];
    logic               lane_act  [NELEM];

    for (genvar g = 0; g < NELEM; g++) begin : g_lane
        assign lane_data[g] = vdata_i[g*DW_BITS +: DW_BITS];
        assign lane_act[g]  = pred_i[g*PRED_PER_ELEM];
    end

    assign data_o   = lane_data[elem_i];
    assign active_o = lane_act[elem_i];

    // Only the lowest bit of each element's predicate slice governs the element.
    logic unused_pred;
    assign unused_pred = ^pred_i;

endmodule

// File: rtl/vstore_seq.sv
module vstore_seq
    import vst_pkg::*;
#(
    parameter  int VLEN   = 256,
    localparam int NELEM  = VLEN / DW_BITS,
    localparam int PRED_W = VLEN / 8,
    localparam int EW     = (NELEM > 1) ? $clog2(NELEM) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [31:0]       instr_i,
    input  logic [63:0]       base_i,
    input  logic [63:0]       index_i,
    input  logic [VLEN-1:0]   vdata_i,
    input  logic [PRED_W-1:0] pred_i,
    output logic              wr_valid_o,
    input  logic              wr_ready_i,
    output logic [63:0]       wr_addr_o,
    output logic [63:0]       wr_data_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              foreign_o,
    output logic              undef_o,
    output logic              misalign_o
);

    state_t state_q, state_d;

    logic              accept;
    logic              adv;
    logic [31:0]       instr_q;
    logic [VLEN-1:0]   vdata_q;
    logic [PRED_W-1:0] pred_q;

    outcome_t                 outcome;
    logic [SP_ALIGN_BITS-1:0] base_lo;
    logic [EW-1:0]            elem;
    logic                     last;
    logic                     active;

    assign accept = start_i && (state_q == S_IDLE);

    // Operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            instr_q <= '0;
            vdata_q <= '0;
            pred_q  <= '0;
        end else if (accept) begin
            instr_q <= instr_i;
            vdata_q <= vdata_i;
            pred_q  <= pred_i;
        end
    end

    vst_decode u_decode (
        .word_i    (instr_q),
        .base_lo_i (base_lo),
        .outcome_o (outcome)
    );

    vst_addr_gen #(.NELEM(NELEM)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept),
        .adv_i     (adv),
        .base_i    (base_i),
        .index_i   (index_i),
        .base_lo_o (base_lo),
        .addr_o    (wr_addr_o),
        .elem_o    (elem),
        .last_o    (last)
    );

    vst_lane_sel #(.VLEN(VLEN)) u_lane (
        .vdata_i  (vdata_q),
        .pred_i   (pred_q),
        .elem_i   (elem),
        .data_o   (wr_data_o),
        .active_o (active)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) state_d = S_DECODE;
            end
            S_DECODE: begin
                unique case (outcome)
                    OUT_FOREIGN:  state_d = S_FOREIGN;
                    OUT_UNDEF:    state_d = S_UNDEF;
                    OUT_MISALIGN: state_d = S_MISALIGN;
                    default:      state_d = S_SCAN;
                endcase
            end
            S_SCAN: begin
                if (active)    state_d = S_WRITE;
                else if (last) state_d = S_DONE;
            end
            S_WRITE: begin
                if (wr_ready_i) state_d = last ? S_DONE : S_SCAN;
            end
            S_DONE, S_FOREIGN, S_UNDEF, S_MISALIGN: begin
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        wr_valid_o = 1'b0;
        adv        = 1'b0;
        done_o     = 1'b0;
        foreign_o  = 1'b0;
        undef_o    = 1'b0;
        misalign_o = 1'b0;
        unique case (state_q)
            S_SCAN:     adv = !active;
            S_WRITE: begin
                wr_valid_o = 1'b1;
                adv        = wr_ready_i;
            end
            S_DONE:     done_o     = 1'b1;
            S_FOREIGN:  foreign_o  = 1'b1;
            S_UNDEF:    undef_o    = 1'b1;
            S_MISALIGN: misalign_o = 1'b1;
            default: ;
        endcase
    end

    assign busy_o = (state_q != S_IDLE);

    // R7: a stalled request holds valid, address and data.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i) |=>
            (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

    // R8: at most one outcome pulse at a time, and each lasts a single cycle.
    p_one_term_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, foreign_o, undef_o, misalign_o}));
    p_term_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || foreign_o || undef_o || misalign_o) |=> !busy_o);

    // R10: no write request while idle.
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !wr_valid_o);

    // R9: a start while busy does not disturb captured operands.
    p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(instr_q) && $stable(pred_q)));

    // R5: every address keeps the base's sub-doubleword offset.
    p_addr_gran_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> (wr_addr_o[2:0] == base_lo[2:0]));

    // R4: a misaligned stack-pointer base never reaches the write phase.
    p_misalign_nowr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DECODE && outcome == OUT_MISALIGN) |=> !wr_valid_o);

endmodule

// File: tb/vstore_seq_tb.sv
`timescale 1ns/1ps
module vstore_seq_tb;

    localparam int VLEN   = 512;
    localparam int NELEM  = VLEN / 64;
    localparam int PRED_W = VLEN / 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [31:0]       instr_i = '0;
    logic [63:0]       base_i = '0;
    logic [63:0]       index_i = '0;
    logic [VLEN-1:0]   vdata_i = '0;
    logic [PRED_W-1:0] pred_i = '0;
    logic              wr_valid_o;
    logic              wr_ready_i = 1'b1;
    logic [63:0]       wr_addr_o;
    logic [63:0]       wr_data_o;
    logic              busy_o, done_o, foreign_o, undef_o, misalign_o;

    always #2.5 clk = ~clk;

    vstore_seq #(.VLEN(VLEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
        .base_i(base_i), .index_i(index_i), .vdata_i(vdata_i), .pred_i(pred_i),
        .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
        .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .busy_o(busy_o),
        .done_o(done_o), .foreign_o(foreign_o), .undef_o(undef_o),
        .misalign_o(misalign_o)
    );

    int n_checks = 0;
    int n_err    = 0;
    int cycles   = 0;
    int n_done = 0, n_foreign = 0, n_undef = 0, n_mis = 0;
    int wcnt = 0;
    int hold_err = 0;
    int rdy_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [63:0] got_addr [0:31];
    logic [63:0] got_data [0:31];
    logic        stall_prev = 1'b0;
    logic [63:0] prev_addr = '0, prev_data = '0;

    // Monitor: handshakes, pulses, hold behaviour, watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst_n) begin
            if (wr_valid_o && wr_ready_i) begin
                if (wcnt < 32) begin
                    got_addr[wcnt] <= wr_addr_o;
                    got_data[wcnt] <= wr_data_o;
                end
                wcnt <= wcnt + 1;
            end
            if (stall_prev && !(wr_valid_o && wr_addr_o == prev_addr && wr_data_o == prev_data))
                hold_err <= hold_err + 1;
            stall_prev <= wr_valid_o && !wr_ready_i;
            prev_addr  <= wr_addr_o;
            prev_data  <= wr_data_o;
            if (done_o)     n_done    <= n_done + 1;
            if (foreign_o)  n_foreign <= n_foreign + 1;
            if (undef_o)    n_undef   <= n_undef + 1;
            if (misalign_o) n_mis     <= n_mis + 1;
        end
        if (cycles > 100000) begin
            n_checks = n_checks + 1;
            n_err = n_err + 1;
            $display("FAIL watchdog: got %0d cycles expected under 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    // Ready driver
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        wr_ready_i <= (rdy_mode == 0) ? 1'b1 : (lfsr[0] & lfsr[3]);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mkword(logic [1:0] size, logic [4:0] ridx, logic [4:0] rbase);
        return {9'b111001011, size, ridx, 3'b010, 3'd2, rbase, 5'd7};
    endfunction

    function automatic logic [VLEN-1:0] mkdata(int seed);
        logic [VLEN-1:0] v;
        for (int e = 0; e < NELEM; e++)
            v[e*64 +: 64] = {32'hD00D0000 + 32'(e + seed), 32'h12340000 ^ 32'(e * 7 + seed * 13)};
        return v;
    endfunction

    // Lowest bit of each slice from mask; other slice bits set to 1.
    function automatic logic [PRED_W-1:0] mkpred(logic [NELEM-1:0] m);
        logic [PRED_W-1:0] p;
        for (int e = 0; e < NELEM; e++)
            p[e*8 +: 8] = {7'h7F, m[e]};
        return p;
    endfunction

    int s_done, s_foreign, s_undef, s_mis;

    task automatic launch(input logic [31:0] w, input logic [63:0] b, input logic [63:0] ix,
                          input logic [VLEN-1:0] vd, input logic [PRED_W-1:0] pd);
        @(negedge clk);
        wcnt = 0;
        s_done = n_done; s_foreign = n_foreign; s_undef = n_undef; s_mis = n_mis;
        instr_i = w; base_i = b; index_i = ix; vdata_i = vd; pred_i = pd;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // kind: 0 done, 1 foreign, 2 undef, 3 misalign
    task automatic finish(input string req, input int kind, input logic [63:0] b,
                          input logic [63:0] ix, input logic [VLEN-1:0] vd,
                          input logic [PRED_W-1:0] pd);
        int guard = 0;
        int exp_n = 0;
        while ((n_done + n_foreign + n_undef + n_mis) == (s_done + s_foreign + s_undef + s_mis)
               && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        repeat (4) @(negedge clk);
        check(n_done - s_done == (kind == 0 ? 1 : 0), req, "done pulses", 64'(n_done - s_done), 64'(kind == 0));
        check(n_foreign - s_foreign == (kind == 1 ? 1 : 0), req, "foreign pulses", 64'(n_foreign - s_foreign), 64'(kind == 1));
        check(n_undef - s_undef == (kind == 2 ? 1 : 0), req, "undef pulses", 64'(n_undef - s_undef), 64'(kind == 2));
        check(n_mis - s_mis == (kind == 3 ? 1 : 0), req, "misalign pulses", 64'(n_mis - s_mis), 64'(kind == 3));
        if (kind == 0) begin
            for (int e = 0; e < NELEM; e++) begin
                if (pd[e*8]) begin
                    if (exp_n < wcnt && exp_n < 32) begin
                        check(got_addr[exp_n] == b + (ix + 64'(e)) * 64'd8, req, "address",
                              got_addr[exp_n], b + (ix + 64'(e)) * 64'd8);
                        check(got_data[exp_n] == vd[e*64 +: 64], req, "data",
                              got_data[exp_n], vd[e*64 +: 64]);
                    end
                    exp_n++;
                end
            end
        end
        check(wcnt == exp_n, req, "write count", 64'(wcnt), 64'(exp_n));
        check(!busy_o, req, "idle after outcome", 64'(busy_o), 64'd0);
    endtask

    task automatic run(input string req, input int kind, input logic [31:0] w,
                       input logic [63:0] b, input logic [63:0] ix,
                       input logic [VLEN-1:0] vd, input logic [PRED_W-1:0] pd);
        launch(w, b, ix, vd, pd);
        finish(req, kind, b, ix, vd, pd);
    endtask

    task automatic t_reset();
        check(!busy_o, "R10", "busy after reset", 64'(busy_o), 64'd0);
        check(!wr_valid_o, "R10", "valid after reset", 64'(wr_valid_o), 64'd0);
        check(!(done_o | foreign_o | undef_o | misalign_o), "R10", "pulses after reset",
              64'({done_o, foreign_o, undef_o, misalign_o}), 64'd0);
    endtask

    task automatic t_all_active();
        run("R5", 0, mkword(2'b11, 5'd4, 5'd2), 64'h0000_1000_0000_0040, 64'd3, mkdata(1), mkpred('1));
        run("R5", 0, mkword(2'b11, 5'd0, 5'd9), 64'h0000_0000_0000_0103, 64'd0, mkdata(5), mkpred('1));
    endtask

    task automatic t_masks();
        run("R6", 0, mkword(2'b11, 5'd1, 5'd2), 64'h2000, 64'd10, mkdata(2), mkpred(8'b1010_0101));
        run("R6", 0, mkword(2'b11, 5'd1, 5'd2), 64'h2000, 64'd0, mkdata(3), mkpred(8'b1000_0000));
        run("R6", 0, mkword(2'b11, 5'd1, 5'd2), 64'h2000, 64'd0, mkdata(4), mkpred(8'b0000_0001));
        run("R8", 0, mkword(2'b11, 5'd1, 5'd2), 64'h2000, 64'd0, mkdata(4), mkpred('0));
    endtask

    task automatic t_wrap();
        run("R5", 0, mkword(2'b11, 5'd6, 5'd8), 64'hFFFF_FFFF_FFFF_FFF0, 64'd0, mkdata(6), mkpred('1));
        run("R5", 0, mkword(2'b11, 5'd6, 5'd8), 64'h100, 64'hFFFF_FFFF_FFFF_FFFE, mkdata(7), mkpred(8'b0110_1101));
    endtask

    task automatic t_stall();
        int h0 = hold_err;
        rdy_mode = 1;
        run("R7", 0, mkword(2'b11, 5'd2, 5'd3), 64'h8000, 64'd5, mkdata(8), mkpred(8'b1111_0111));
        rdy_mode = 0;
        check(hold_err == h0, "R7", "held request changed", 64'(hold_err - h0), 64'd0);
    endtask

    task automatic t_foreign();
        run("R1", 1, mkword(2'b00, 5'd31, 5'd31), 64'h1, 64'd0, mkdata(9), mkpred('1));
        run("R1", 1, mkword(2'b01, 5'd2, 5'd3), 64'h0, 64'd0, mkdata(9), mkpred('1));
        run("R1", 1, mkword(2'b11, 5'd2, 5'd3) ^ 32'h8000_0000, 64'h0, 64'd0, mkdata(9), mkpred('1));
        run("R1", 1, mkword(2'b11, 5'd2, 5'd3) ^ 32'h0000_4000, 64'h0, 64'd0, mkdata(9), mkpred('1));
    endtask

    task automatic t_undef();
        run("R2", 2, mkword(2'b10, 5'd2, 5'd3), 64'h0, 64'd0, mkdata(10), mkpred('1));
        run("R2", 2, mkword(2'b10, 5'd31, 5'd31), 64'h7, 64'd0, mkdata(10), mkpred('1));
        run("R3", 2, mkword(2'b11, 5'd31, 5'd3), 64'h0, 64'd0, mkdata(11), mkpred('1));
        run("R3", 2, mkword(2'b11, 5'd31, 5'd31), 64'h8, 64'd0, mkdata(11), mkpred('1));
    endtask

    task automatic t_align();
        run("R4", 3, mkword(2'b11, 5'd2, 5'd31), 64'h1008, 64'd0, mkdata(12), mkpred('1));
        run("R4", 3, mkword(2'b11, 5'd2, 5'd31), 64'h1001, 64'd0, mkdata(12), mkpred('1));
        run("R4", 0, mkword(2'b11, 5'd2, 5'd31), 64'h1000, 64'd2, mkdata(13), mkpred(8'b0011_1100));
        run("R4", 0, mkword(2'b11, 5'd2, 5'd30), 64'h1004, 64'd1, mkdata(14), mkpred('1));
    endtask

    task automatic t_busy();
        logic [63:0] b = 64'h4000;
        logic [63:0] ix = 64'd7;
        logic [VLEN-1:0] vd = mkdata(15);
        logic [PRED_W-1:0] pd = mkpred(8'b1101_1011);
        rdy_mode = 1;
        launch(mkword(2'b11, 5'd2, 5'd3), b, ix, vd, pd);
        repeat (3) @(negedge clk);
        instr_i = mkword(2'b00, 5'd2, 5'd3); base_i = 64'h9999; index_i = 64'd100;
        vdata_i = mkdata(99); pred_i = '1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        finish("R9", 0, b, ix, vd, pd);
        rdy_mode = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_all_active();
        t_masks();
        t_wrap();
        t_stall();
        t_foreign();
        t_undef();
        t_align();
        t_busy();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule